// File: doc/BRIEF.md
# Prioritizing Interrupt Controller

This block collects a set of level-sensitive interrupt request lines (128 by default) and turns them into a single interrupt line toward a processor. Software gives each source an enable mask bit and a small urgency value, where a lower value means more urgent. Software also sets a global cut-off that a source's urgency must beat before the source can raise the interrupt. Whenever no decision is outstanding, the controller scans all eligible sources in one cycle. It records the winner's number and raises the interrupt line.

A recorded decision stays frozen. No later request, not even a more urgent one, replaces it until software writes the acknowledge bit. The interrupt handler reads a status word to learn the source number. If that source dropped its request or was masked after it was recorded, the status word flags the decision as spurious instead of naming a source. The handler must still acknowledge it. Every access goes through a small synchronous register port: writes take effect on the clock edge, and reads return data in the same cycle.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_o is low and every mask register reads 0xFFFFFFFF. The threshold register reads 0x40, each priority register reads 0, and the status word has bits [31:7] all ones.
- R2: The mask register at 0x10 + 4*k holds, at bit b, the mask of source 32*k + b. A 1 keeps that source out of arbitration and a 0 admits it.
- R3: A source competes only when its line is high, it is unmasked, and its priority is strictly less than the threshold value held in bits [6:0] of the register at 0x08. A priority equal to the threshold is blocked.
- R4: The priority of source n sits in bits [5:0] of the register at 0x100 + 4*n. Among competing sources the smallest value wins, and on equal values the lowest source number wins.
- R5: With no decision outstanding, a competing source present at a rising edge makes irq_o high after that edge. The status word at 0x00 then reads the winner's number in bits [6:0] with bits [31:7] zero.
- R6: While irq_o is high and no acknowledge is written, irq_o stays high and the recorded number does not change, even when a more urgent source arrives.
- R7: Writing 0x04 with bit 0 set drops irq_o after that edge, and arbitration restarts at the next edge, so irq_o is low for at least one cycle. A write to 0x04 with bit 0 clear has no effect.
- R8: If the recorded source's line goes low, or its mask bit becomes 1, while the decision is outstanding, status bits [31:7] read all ones from the following cycle. They stay all ones until the acknowledge, even if the source comes back.
- R9: A spurious decision keeps irq_o high until it is acknowledged, and the acknowledge clears the spurious flag.
- R10: Whenever no decision is outstanding, status bits [31:7] read all ones, and bits [6:0] carry no meaning.
- R11: The threshold, mask and priority registers read back their stored values. The control register reads 0, and bus_rdata is 0 unless a read (bus_en high, bus_we low) is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 128 | Level-sensitive request lines, one per source |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| irq_o | output | 1 | Interrupt request toward the processor |

## Verification
The assertions assume that the source lines and bus signals change only away from the rising edge and are stable at it. They also assume that reset is held across at least one edge before the first access, so the first winner is taken from reset contents. The bench changes every input one time unit after the falling edge and releases reset only after several cycles. It writes only word-aligned addresses inside the map, so every access lands on a defined register.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned ACK_BIT  = 0;
    localparam logic [ADDR_W-1:0] ADDR_STATUS    = 12'h000;
    localparam logic [ADDR_W-1:0] ADDR_CTRL      = 12'h004;
    localparam logic [ADDR_W-1:0] ADDR_THRESH    = 12'h008;
    localparam logic [ADDR_W-1:0] ADDR_MASK_BASE = 12'h010;
    localparam logic [ADDR_W-1:0] ADDR_PRIO_BASE = 12'h100;
endpackage

// File: rtl/ictl_arbiter.sv
module ictl_arbiter #(
    parameter int unsigned NUM_SRC = 128,
    parameter int unsigned PRIO_W  = 6,
    parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W:0]                thresh_i,
    output logic                           found_o,
    output logic [IDX_W-1:0]               idx_o
);
    logic [PRIO_W-1:0] best;

    // Ascending scan with strict compare: equal urgency keeps the lower index.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && ({1'b0, prio_i[i]} < thresh_i) &&
                (!found_o || (prio_i[i] < best))) begin
                found_o = 1'b1;
                best    = prio_i[i];
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ictl_cfg.sv
module ictl_cfg import ictl_pkg::*; #(
    parameter int unsigned NUM_SRC = 128,
    parameter int unsigned PRIO_W  = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [NUM_SRC-1:0]             mask_o,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
    output logic [PRIO_W:0]                thresh_o,
    output logic [DATA_W-1:0]              rdata_o
);
    localparam int unsigned MASK_REGS = (NUM_SRC + WORD_W - 1) / WORD_W;
    localparam int unsigned MASK_W    = MASK_REGS * WORD_W;

    typedef struct packed {
        logic [MASK_W-1:0]              mask;
        logic [PRIO_W:0]                thresh;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            if (addr_i == ADDR_THRESH) cfg_d.thresh = wdata_i[PRIO_W:0];
            for (int k = 0; k < MASK_REGS; k++) begin
                if (addr_i == ADDR_MASK_BASE + ADDR_W'(4 * k))
                    cfg_d.mask[k*WORD_W +: WORD_W] = wdata_i;
            end
            for (int n = 0; n < NUM_SRC; n++) begin
                if (addr_i == ADDR_PRIO_BASE + ADDR_W'(4 * n))
                    cfg_d.prio[n] = wdata_i[PRIO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask   <= '1;
            cfg_q.thresh <= (PRIO_W+1)'(1) << PRIO_W;
            cfg_q.prio   <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_THRESH) rdata_o[PRIO_W:0] = cfg_q.thresh;
        for (int k = 0; k < MASK_REGS; k++) begin
            if (addr_i == ADDR_MASK_BASE + ADDR_W'(4 * k))
                rdata_o = cfg_q.mask[k*WORD_W +: WORD_W];
        end
        for (int n = 0; n < NUM_SRC; n++) begin
            if (addr_i == ADDR_PRIO_BASE + ADDR_W'(4 * n))
                rdata_o[PRIO_W-1:0] = cfg_q.prio[n];
        end
    end

    assign mask_o   = cfg_q.mask[NUM_SRC-1:0];
    assign prio_o   = cfg_q.prio;
    assign thresh_o = cfg_q.thresh;
endmodule

// File: rtl/prio_intc.sv
module prio_intc import ictl_pkg::*; #(
    parameter int unsigned NUM_SRC = 128,
    parameter int unsigned PRIO_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);
    localparam int unsigned IDX_W  = $clog2(NUM_SRC);
    localparam int unsigned FLAG_W = DATA_W - IDX_W;

    typedef struct packed {
        logic             held;
        logic             spur;
        logic [IDX_W-1:0] win;
    } dec_t;

    dec_t dec_d, dec_q;

    logic [NUM_SRC-1:0]             mask;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic [PRIO_W:0]                thresh;
    logic [DATA_W-1:0]              cfg_rdata;
    logic                           arb_found;
    logic [IDX_W-1:0]               arb_idx;
    logic [IDX_W-1:0]               win_q;
    logic                           wr_en;
    logic                           ack;
    logic                           vanished;
    logic                           valid;

    ictl_cfg #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .mask_o   (mask),
        .prio_o   (prio),
        .thresh_o (thresh),
        .rdata_o  (cfg_rdata)
    );

    ictl_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .req_i    (src_i & ~mask),
        .prio_i   (prio),
        .thresh_i (thresh),
        .found_o  (arb_found),
        .idx_o    (arb_idx)
    );

    assign wr_en    = bus_en && bus_we;
    assign ack      = wr_en && (bus_addr == ADDR_CTRL) && bus_wdata[ACK_BIT];
    assign win_q    = dec_q.win;
    assign vanished = !src_i[win_q] || mask[win_q];

    always_comb begin
        dec_d = dec_q;
        if (dec_q.held) begin
            if (ack) begin
                dec_d.held = 1'b0;
                dec_d.spur = 1'b0;
            end else if (vanished) begin
                dec_d.spur = 1'b1;
            end
        end else if (arb_found) begin
            dec_d.held = 1'b1;
            dec_d.spur = 1'b0;
            dec_d.win  = arb_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign valid = dec_q.held && !dec_q.spur;
    assign irq_o = dec_q.held;

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            if (bus_addr == ADDR_STATUS) bus_rdata = {{FLAG_W{!valid}}, win_q};
            else                         bus_rdata = cfg_rdata;
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk import ictl_pkg::*; #(
    parameter int unsigned NUM_SRC = 128,
    parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              ack_bit,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              arb_found,
    input logic [IDX_W-1:0]  win_q
);
    logic rd_status, ack_wr;
    logic [DATA_W-IDX_W-1:0] flag;
    assign rd_status = bus_en && !bus_we && (bus_addr == ADDR_STATUS);
    assign ack_wr    = bus_en && bus_we && (bus_addr == ADDR_CTRL) && ack_bit;
    assign flag      = bus_rdata[DATA_W-1:IDX_W];

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !ack_wr |=> irq_o); // R6
    AST_WIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !ack_wr |=> $stable(win_q)); // R6
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && ack_wr |=> !irq_o); // R7
    AST_RISE_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(arb_found)); // R5
    AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status && !irq_o |-> (flag == '1)); // R10
    AST_FLAG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |-> (flag == '1 || flag == '0)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status && irq_o && !ack_wr && (flag == '1) |=> (!rd_status || flag == '1)); // R8
endmodule

bind prio_intc prio_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .ack_bit   (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .arb_found (arb_found),
    .win_q     (win_q)
);

// File: tb/tb_prio_intc.sv
`timescale 1ns/1ps
module tb_prio_intc;
    localparam int N  = 128;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_o;

    always #4 clk = ~clk;

    prio_intc #(.NUM_SRC(N), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    int checks = 0;
    int failures = 0;

    // Behavioural reference model
    bit m_held, m_spur;
    int m_win;
    bit m_mask[N];
    int m_prio[N];
    int m_thr;

    function automatic int pick();
        int w = -1;
        for (int i = 0; i < N; i++)
            if (src[i] && !m_mask[i] && m_prio[i] < m_thr && (w < 0 || m_prio[i] < m_prio[w]))
                w = i;
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a, output logic [31:0] cm);
        logic [31:0] v = 32'h0;
        cm = 32'hFFFF_FFFF;
        if (a == 12'h000) begin
            if (m_held && !m_spur) v = 32'(m_win);
            else begin v = 32'hFFFF_FF80; cm = 32'hFFFF_FF80; end
        end else if (a == 12'h008) v = 32'(m_thr);
        else if (a >= 12'h010 && a <= 12'h01C) begin
            for (int b = 0; b < 32; b++) v[b] = m_mask[(int'(a) - 16) / 4 * 32 + b];
        end else if (a >= 12'h100 && a < 12'h300) v = 32'(m_prio[(int'(a) - 256) / 4]);
        return v;
    endfunction

    always @(posedge clk) begin
        int w;
        if (!rst_n) begin
            m_held = 0; m_spur = 0; m_win = 0; m_thr = 64;
            for (int i = 0; i < N; i++) begin m_mask[i] = 1; m_prio[i] = 0; end
        end else begin
            w = pick();
            if (m_held) begin
                if (bus_en && bus_we && bus_addr == 12'h004 && bus_wdata[0]) begin
                    m_held = 0; m_spur = 0;
                end else if (!src[m_win] || m_mask[m_win]) m_spur = 1;
            end else if (w >= 0) begin
                m_held = 1; m_spur = 0; m_win = w;
            end
            if (bus_en && bus_we) begin
                if (bus_addr == 12'h008) m_thr = int'(bus_wdata[6:0]);
                else if (bus_addr >= 12'h010 && bus_addr <= 12'h01C && bus_addr[1:0] == 2'b00) begin
                    for (int b = 0; b < 32; b++) m_mask[(int'(bus_addr) - 16) / 4 * 32 + b] = bus_wdata[b];
                end else if (bus_addr >= 12'h100 && bus_addr < 12'h300 && bus_addr[1:0] == 2'b00)
                    m_prio[(int'(bus_addr) - 256) / 4] = int'(bus_wdata[5:0]);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        logic [31:0] e, cm;
        if (rst_n) begin
            check(irq_o === m_held, "R6 irq level vs model", 32'(irq_o), 32'(m_held));
            if (bus_en && !bus_we) begin
                e = exp_read(bus_addr, cm);
                check(((bus_rdata ^ e) & cm) == 0, "R11 read data vs model", bus_rdata, e);
            end
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input logic [31:0] cm, input string tag);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1;
        check(((bus_rdata ^ e) & cm) == 0, tag, bus_rdata, e);
        bus_en = 0;
    endtask

    task automatic irq_chk(input bit e, input string tag);
        check(irq_o === e, tag, 32'(irq_o), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int r;
        logic [11:0] a;
        repeat (4) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        irq_chk(0, "R1 irq after reset");
        for (int k = 0; k < 4; k++) rd_chk(12'h010 + 12'(4 * k), 32'hFFFF_FFFF, '1, "R1 mask reset");
        rd_chk(12'h008, 32'h40, '1, "R1 threshold reset");
        rd_chk(12'h100, 32'h0, '1, "R1 priority 0 reset");
        rd_chk(12'h2FC, 32'h0, '1, "R1 priority 127 reset");
        rd_chk(12'h000, 32'hFFFF_FF80, 32'hFFFF_FF80, "R1 status flag reset");
        rd_chk(12'h004, 32'h0, '1, "R11 control reads zero");
        // R2 masked source ignored
        src[5] = 1; repeat (3) tick();
        irq_chk(0, "R2 masked source blocked");
        src[5] = 0;
        wr(12'h114, 3); wr(12'h218, 1); wr(12'h290, 1);
        rd_chk(12'h218, 32'h1, '1, "R11 priority readback");
        for (int k = 0; k < 4; k++) wr(12'h010 + 12'(4 * k), 0);
        irq_chk(0, "R5 idle without requests");
        // R4 priority then lowest index
        src[5] = 1; src[70] = 1; src[100] = 1;
        tick();
        irq_chk(1, "R5 irq after winner");
        rd_chk(12'h000, 32'd70, '1, "R4 urgency then lowest index");
        // R6 frozen decision
        src[2] = 1; repeat (2) tick();
        rd_chk(12'h000, 32'd70, '1, "R6 no preemption while held");
        wr(12'h004, 0);
        irq_chk(1, "R7 control bit0 clear ignored");
        wr(12'h004, 1);
        irq_chk(0, "R7 ack drops irq");
        rd_chk(12'h000, 32'hFFFF_FF80, 32'hFFFF_FF80, "R10 idle status flag");
        tick();
        irq_chk(1, "R7 arbitration restarts");
        rd_chk(12'h000, 32'd2, '1, "R5 new winner source 2");
        // R8 / R9 vanished source
        src[2] = 0; tick();
        rd_chk(12'h000, 32'hFFFF_FF80, 32'hFFFF_FF80, "R8 deasserted source spurious");
        src[2] = 1; tick();
        rd_chk(12'h000, 32'hFFFF_FF80, 32'hFFFF_FF80, "R8 spurious sticky");
        irq_chk(1, "R9 spurious keeps irq");
        wr(12'h004, 1); tick();
        rd_chk(12'h000, 32'd2, '1, "R9 ack clears spurious");
        wr(12'h010, 32'h4); tick();
        rd_chk(12'h000, 32'hFFFF_FF80, 32'hFFFF_FF80, "R8 masked source spurious");
        wr(12'h004, 1); tick();
        rd_chk(12'h000, 32'd70, '1, "R2 masked source skipped");
        // R3 strict threshold
        wr(12'h008, 1); wr(12'h004, 1); repeat (2) tick();
        irq_chk(0, "R3 priority equal to threshold blocked");
        wr(12'h218, 0); tick();
        irq_chk(1, "R3 priority below threshold passes");
        rd_chk(12'h000, 32'd70, '1, "R3 winner under threshold");
        wr(12'h004, 1);
        wr(12'h008, 64);
        // Random phase, checked every cycle against the model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 8 == 0) src = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
            r = int'($urandom % 16);
            bus_en = 0; bus_we = 0;
            if (irq_o && r < 4) begin
                bus_en = 1; bus_we = 1; bus_addr = 12'h004; bus_wdata = 32'($urandom % 2);
            end else if (r == 4) begin
                bus_en = 1; bus_we = 1; bus_addr = 12'h100 + 12'(4 * ($urandom % N)); bus_wdata = $urandom;
            end else if (r == 5) begin
                bus_en = 1; bus_we = 1; bus_addr = 12'h010 + 12'(4 * ($urandom % 4)); bus_wdata = $urandom & $urandom;
            end else if (r == 6) begin
                bus_en = 1; bus_we = 1; bus_addr = 12'h008; bus_wdata = 32'($urandom % 66);
            end else if (r < 11) begin
                case ($urandom % 4)
                    0: a = 12'h000;
                    1: a = 12'h008;
                    2: a = 12'h010 + 12'(4 * ($urandom % 4));
                    default: a = 12'h100 + 12'(4 * ($urandom % N));
                endcase
                bus_en = 1; bus_we = 0; bus_addr = a;
            end
            tick();
        end
        bus_en = 0; bus_we = 0;
        tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule